// File: doc/BRIEF.md
# Non-volatile memory access guard

The guard sits in front of the program flash and data EEPROM and rules on every access in the cycle it is presented. It weighs the access (address, direction and requesting master) against three stored option values: a readout-protection level, a per-sector write-protect mask and a sticky write-violation status bit. It also weighs two live signals: whether a debugger is attached and whether the part booted from RAM. Granted accesses pass on to the array. Denied ones never reach it. They return zero data and raise a one-cycle bus error.

The level and the mask come from stored option values when reset is active. Software can then rewrite them through a small register port, unless the strongest level is in force. The strongest level also turns off the debug port and RAM boot until the next full reset.

Top module: `nvm_access_guard`

## Requirements
- R1: While `rst` is high the level register loads `boot_level` and the mask loads `boot_wp`. The write-violation status clears, and `bus_err` is low in the first cycle after reset.
- R2: Level encoding: 2'b00 is open, 2'b11 is chip lock, and 2'b01 or 2'b10 is read lock. Register select 0 reads back the raw two bits in [1:0], select 1 reads the mask, select 2 reads the status in bit 0, and select 3 reads zero.
- R3: At the open level, accesses are decided only by write protection. `dbg_attached` and `boot_ram` have no effect.
- R4: At read lock, every access (read or write, flash or EEPROM) is denied while `dbg_attached` or `boot_ram` is high. Otherwise accesses are decided by write protection.
- R5: At chip lock, `dbg_port_en` and `ram_boot_en` are low, and they are high at every other level. Accesses from master ID 3 (the debug master) are denied at chip lock. Other masters ignore `dbg_attached` and `boot_ram`.
- R6: At chip lock, register writes to the level and the mask are ignored. Only reset reloads them.
- R7: The sector index is `req_addr[17:12]` (4 KB sectors). Sectors 0 to 31 are program flash, and sector n is write-protected when mask bit n is 1. A write to a protected sector is denied and a read is allowed. Sectors 32 and above (EEPROM) are never write-protected.
- R8: A denied access gives `bus_err` high for exactly the next cycle and `rsp_rdata` zero. A granted read gives `rsp_valid` high and `rsp_rdata` equal to `mem_rdata` in the next cycle.
- R9: A write that hits a protected sector sets the sticky `wp_err`. Writing 1 to bit 0 of select 2 clears it. When both happen in one cycle, the set wins.
- R10: `req_grant` and `req_deny` are combinational and never both high. `mem_we` and `mem_re` follow a grant, and `mem_addr` is zero unless the access is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads option values |
| boot_level | input | 2 | Stored level value loaded at reset |
| boot_wp | input | 32 | Stored write-protect mask loaded at reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| req_valid | input | 1 | Access request present |
| req_addr | input | 18 | Byte address of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_master | input | 2 | Requesting master ID |
| dbg_attached | input | 1 | Debugger connected |
| boot_ram | input | 1 | RAM boot selected |
| req_grant | output | 1 | Access granted this cycle |
| req_deny | output | 1 | Access denied this cycle |
| mem_re | output | 1 | Read strobe to the array |
| mem_we | output | 1 | Write strobe to the array |
| mem_addr | output | 18 | Address to the array, zero unless granted |
| mem_rdata | input | 32 | Array read data, one cycle after `mem_re` |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data returned to the bus, zero unless valid |
| bus_err | output | 1 | One-cycle error pulse after a denial |
| wp_err | output | 1 | Sticky write-violation status |
| dbg_port_en | output | 1 | Debug port enable |
| ram_boot_en | output | 1 | RAM boot enable |

## Verification
The hardest states to reach are chip lock and the cycle where a violation and a software clear of the status land together. Chip lock cannot be left once entered. The set-and-clear collision needs an access and a register write aligned to the same edge. The stimulus keeps random level writes below chip lock while it explores the open and read-lock levels with random flags, masters and sectors. It then enters chip lock on purpose, tries to lower it, and leaves only through reset with a chip-lock value on `boot_level`. The collision is driven as a directed case with both strobes raised on the same falling edge.

// File: rtl/nag_pkg.sv
package nag_pkg;

    localparam int SECTOR_BITS = 12;

    localparam logic [1:0] SEL_LEVEL  = 2'd0;
    localparam logic [1:0] SEL_WPMASK = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

    typedef enum logic [1:0] {
        RDP_OPEN      = 2'd0,
        RDP_READ_LOCK = 2'd1,
        RDP_CHIP_LOCK = 2'd2
    } rdp_e;

    typedef struct packed {
        logic grant;
        logic deny;
        logic wp_hit;
        logic is_read;
    } verdict_t;

    // Only the two exact patterns 00 and 11 select the outer levels;
    // any disturbed pattern lands on the middle, protective level.
    function automatic rdp_e rdp_decode(input logic [1:0] raw);
        case (raw)
            2'b00:   return RDP_OPEN;
            2'b11:   return RDP_CHIP_LOCK;
            default: return RDP_READ_LOCK;
        endcase
    endfunction

endpackage

// File: rtl/nag_opt_regs.sv
module nag_opt_regs
    import nag_pkg::*;
#(
    parameter int PROG_SECTORS = 32,
    parameter int DW           = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              boot_level,
    input  logic [PROG_SECTORS-1:0] boot_wp,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [DW-1:0]           reg_wdata,
    input  logic                    wp_set,
    output logic [DW-1:0]           reg_rdata,
    output rdp_e                    level,
    output logic [PROG_SECTORS-1:0] wp_mask,
    output logic                    wp_err
);

    logic [1:0]              lvl_q;
    logic [PROG_SECTORS-1:0] mask_q;
    logic                    err_q;
    logic                    locked;
    logic                    clr_req;

    assign locked  = (rdp_decode(lvl_q) == RDP_CHIP_LOCK);
    assign clr_req = reg_we && (reg_sel == SEL_STATUS) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= boot_level;
            mask_q <= boot_wp;
            err_q  <= 1'b0;
        end else begin
            if (reg_we && !locked) begin
                if (reg_sel == SEL_LEVEL)  lvl_q  <= reg_wdata[1:0];
                if (reg_sel == SEL_WPMASK) mask_q <= reg_wdata[PROG_SECTORS-1:0];
            end
            if (wp_set)       err_q <= 1'b1;
            else if (clr_req) err_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_LEVEL:  reg_rdata = DW'(lvl_q);
            SEL_WPMASK: reg_rdata = DW'(mask_q);
            SEL_STATUS: reg_rdata = DW'(err_q);
            default:    reg_rdata = '0;
        endcase
    end

    assign level   = rdp_decode(lvl_q);
    assign wp_mask = mask_q;
    assign wp_err  = err_q;

    a_r6_lock_freezes: assert property (@(posedge clk) disable iff (rst)
        (locked && reg_we) |=> ($stable(lvl_q) && $stable(mask_q)));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_req) |=> err_q);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        wp_set |=> err_q);

endmodule

// File: rtl/nag_decide.sv
module nag_decide
    import nag_pkg::*;
#(
    parameter int AW           = 18,
    parameter int PROG_SECTORS = 32,
    parameter int MW           = 2,
    parameter int DBG_MASTER   = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [AW-SECTOR_BITS-1:0]    sector,
    input  logic                         req_write,
    input  logic [MW-1:0]                req_master,
    input  rdp_e                         level,
    input  logic [PROG_SECTORS-1:0]      wp_mask,
    input  logic                         dbg_attached,
    input  logic                         boot_ram,
    output verdict_t                     verdict
);

    localparam int PSW = $clog2(PROG_SECTORS);

    logic in_prog;
    logic prot_bit;
    logic rdp_block;

    assign in_prog  = int'(sector) < PROG_SECTORS;
    assign prot_bit = in_prog && wp_mask[sector[PSW-1:0]];

    always_comb begin
        case (level)
            RDP_OPEN:      rdp_block = 1'b0;
            RDP_CHIP_LOCK: rdp_block = (req_master == MW'(DBG_MASTER));
            default:       rdp_block = dbg_attached || boot_ram;
        endcase
    end

    always_comb begin
        verdict.is_read = !req_write;
        verdict.wp_hit  = req_valid && req_write && prot_bit;
        verdict.grant   = req_valid && !rdp_block && !(req_write && prot_bit);
        verdict.deny    = req_valid && !verdict.grant;
    end

    a_r4_read_lock_blocks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && level == RDP_READ_LOCK && (dbg_attached || boot_ram)) |-> verdict.deny);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({verdict.grant, verdict.deny}));

endmodule

// File: rtl/nag_resp.sv
module nag_resp
    import nag_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  verdict_t      verdict,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_err
);

    logic rd_ok_q;
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            rd_ok_q <= verdict.grant && verdict.is_read;
            err_q   <= verdict.deny;
        end
    end

    assign rsp_valid = rd_ok_q;
    assign rsp_rdata = rd_ok_q ? mem_rdata : '0;
    assign bus_err   = err_q;

    a_r8_err_follows_deny: assert property (@(posedge clk) disable iff (rst)
        verdict.deny |=> bus_err);

    a_r8_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (rsp_rdata == '0 && !rsp_valid));

endmodule

// File: rtl/nvm_access_guard.sv
module nvm_access_guard
    import nag_pkg::*;
#(
    parameter int AW           = 18,
    parameter int PROG_SECTORS = 32,
    parameter int DW           = 32,
    parameter int MW           = 2,
    parameter int DBG_MASTER   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              boot_level,
    input  logic [PROG_SECTORS-1:0] boot_wp,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [DW-1:0]           reg_wdata,
    output logic [DW-1:0]           reg_rdata,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_write,
    input  logic [MW-1:0]           req_master,
    input  logic                    dbg_attached,
    input  logic                    boot_ram,
    output logic                    req_grant,
    output logic                    req_deny,
    output logic                    mem_re,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    input  logic [DW-1:0]           mem_rdata,
    output logic                    rsp_valid,
    output logic [DW-1:0]           rsp_rdata,
    output logic                    bus_err,
    output logic                    wp_err,
    output logic                    dbg_port_en,
    output logic                    ram_boot_en
);

    localparam int PSW = $clog2(PROG_SECTORS);

    rdp_e                    level;
    logic [PROG_SECTORS-1:0] wp_mask;
    verdict_t                verdict;

    nag_opt_regs #(.PROG_SECTORS(PROG_SECTORS), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .boot_level(boot_level),
        .boot_wp   (boot_wp),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .wp_set    (verdict.wp_hit),
        .reg_rdata (reg_rdata),
        .level     (level),
        .wp_mask   (wp_mask),
        .wp_err    (wp_err)
    );

    nag_decide #(.AW(AW), .PROG_SECTORS(PROG_SECTORS), .MW(MW), .DBG_MASTER(DBG_MASTER)) u_decide (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .sector      (req_addr[AW-1:SECTOR_BITS]),
        .req_write   (req_write),
        .req_master  (req_master),
        .level       (level),
        .wp_mask     (wp_mask),
        .dbg_attached(dbg_attached),
        .boot_ram    (boot_ram),
        .verdict     (verdict)
    );

    nag_resp #(.DW(DW)) u_resp (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .bus_err  (bus_err)
    );

    assign req_grant   = verdict.grant;
    assign req_deny    = verdict.deny;
    assign mem_re      = verdict.grant && verdict.is_read;
    assign mem_we      = verdict.grant && !verdict.is_read;
    assign mem_addr    = verdict.grant ? req_addr : '0;
    assign dbg_port_en = (level != RDP_CHIP_LOCK);
    assign ram_boot_en = (level != RDP_CHIP_LOCK);

    a_r7_no_protected_write: assert property (@(posedge clk) disable iff (rst)
        (mem_we && int'(req_addr[AW-1:SECTOR_BITS]) < PROG_SECTORS)
            |-> !wp_mask[req_addr[SECTOR_BITS +: PSW]]);

    a_r5_lock_kills_debug: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_LEVEL && reg_rdata[1:0] == 2'b11) |-> (!dbg_port_en && !ram_boot_en));

    a_r10_strobes_need_grant: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> (req_valid && !req_deny));

endmodule

// File: tb/test_nvm_access_guard.sv
module test_nvm_access_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  boot_level = 2'b00;
    logic [31:0] boot_wp = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_master = 2'd0;
    logic        dbg_attached = 1'b0;
    logic        boot_ram = 1'b0;
    logic        req_grant, req_deny, mem_re, mem_we;
    logic [17:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_err, wp_err, dbg_port_en, ram_boot_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [1:0]  m_lvl;
    logic [31:0] m_mask;
    bit          m_err;

    always #2 clk = ~clk;

    nvm_access_guard i_nvm_access_guard (
        .clk(clk), .rst(rst), .boot_level(boot_level), .boot_wp(boot_wp),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_master(req_master), .dbg_attached(dbg_attached), .boot_ram(boot_ram),
        .req_grant(req_grant), .req_deny(req_deny), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bus_err(bus_err), .wp_err(wp_err),
        .dbg_port_en(dbg_port_en), .ram_boot_en(ram_boot_en)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_prot(logic [31:0] m, logic [17:0] a, bit w);
        int s = int'(a[17:12]);
        return w && (s < 32) && m[s[4:0]];
    endfunction

    function automatic bit exp_allow(logic [1:0] lv, logic [31:0] m, logic [17:0] a,
                                     bit w, logic [1:0] ms, bit d, bit b);
        bit blk;
        case (lv)
            2'b00:   blk = 1'b0;
            2'b11:   blk = (ms == 2'd3);
            default: blk = d || b;
        endcase
        return !blk && !exp_prot(m, a, w);
    endfunction

    function automatic string lvl_tag(logic [1:0] lv);
        if (lv == 2'b00) return "R3";
        if (lv == 2'b11) return "R5";
        return "R4";
    endfunction

    task automatic do_reset(input logic [1:0] lv, input logic [31:0] wp);
        @(negedge clk);
        boot_level = lv;
        boot_wp    = wp;
        rst        = 1'b1;
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        m_lvl  = lv;
        m_mask = wp;
        m_err  = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        if (m_lvl != 2'b11) begin
            if (sel == 2'd0) m_lvl = d[1:0];
            if (sel == 2'd1) m_mask = d;
        end
        if (sel == 2'd2 && d[0]) m_err = 1'b0;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic access(input logic [17:0] a, input bit w, input logic [1:0] ms,
                          input bit d, input bit b, input string tag);
        bit e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_master = ms;
        dbg_attached = d; boot_ram = b;
        mem_rdata = 32'hC0DE_0000 ^ 32'(a);
        e = exp_allow(m_lvl, m_mask, a, w, ms, d, b);
        #1;
        chk(req_grant == e && req_deny == !e, {tag, " grant"}, 32'(req_grant), 32'(e));
        chk(mem_we == (e && w) && mem_re == (e && !w), "R10 strobes", {mem_we, mem_re}, {e && w, e && !w});
        chk(mem_addr == (e ? a : 18'd0), "R10 mem_addr", 32'(mem_addr), 32'(e ? a : 18'd0));
        if (exp_prot(m_mask, a, w)) m_err = 1'b1;
        @(posedge clk);
        #1;
        chk(bus_err == !e, "R8 bus_err", 32'(bus_err), 32'(!e));
        chk(rsp_rdata == ((e && !w) ? mem_rdata : 32'd0), "R8 rsp_rdata", rsp_rdata,
            (e && !w) ? mem_rdata : 32'd0);
        chk(wp_err == m_err, "R9 wp_err", 32'(wp_err), 32'(m_err));
        chk(dbg_port_en == (m_lvl != 2'b11) && ram_boot_en == (m_lvl != 2'b11),
            "R5 enables", 32'(dbg_port_en), 32'(m_lvl != 2'b11));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5EED_0F1A));

        // R1: reset loads stored option values
        do_reset(2'b00, 32'h0000_00F0);
        reg_rd(2'd0, rd); chk(rd == 32'd0, "R1 level load", rd, 32'd0);
        reg_rd(2'd1, rd); chk(rd == 32'h0000_00F0, "R1 mask load", rd, 32'h0000_00F0);
        reg_rd(2'd2, rd); chk(rd == 32'd0, "R1 status clear", rd, 32'd0);
        reg_rd(2'd3, rd); chk(rd == 32'd0, "R2 select 3 zero", rd, 32'd0);
        chk(bus_err == 1'b0, "R1 bus_err low", 32'(bus_err), 32'd0);

        // R7: protected sector 4 refuses writes, allows reads; EEPROM open
        access(18'h0_4010, 1'b1, 2'd0, 1'b0, 1'b0, "R7 protected write");
        access(18'h0_4010, 1'b0, 2'd0, 1'b0, 1'b0, "R7 protected read");
        access(18'h2_0004, 1'b1, 2'd0, 1'b0, 1'b0, "R7 eeprom write");
        access(18'h0_8000, 1'b1, 2'd0, 1'b0, 1'b0, "R7 sector 8 write");

        // R9: clear by writing 1, then set and clear in one cycle
        reg_wr(2'd2, 32'd1);
        reg_rd(2'd2, rd); chk(rd == 32'd0, "R9 clear", rd, 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 18'h0_5000; req_write = 1'b1; req_master = 2'd0;
        dbg_attached = 1'b0; boot_ram = 1'b0;
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'd1;
        @(negedge clk);
        req_valid = 1'b0; reg_we = 1'b0;
        m_err = 1'b1;
        chk(wp_err == 1'b1, "R9 set wins", 32'(wp_err), 32'd1);

        // R3: flags ignored at open level
        access(18'h0_0100, 1'b0, 2'd3, 1'b1, 1'b1, "R3 open with flags");

        // R2/R4: both middle encodings block on debug or RAM boot
        reg_wr(2'd0, 32'd2);
        reg_rd(2'd0, rd); chk(rd == 32'd2, "R2 raw readback", rd, 32'd2);
        access(18'h0_0100, 1'b0, 2'd0, 1'b1, 1'b0, "R4 enc10 debug");
        access(18'h2_0100, 1'b0, 2'd0, 1'b0, 1'b1, "R4 eeprom ram boot");
        access(18'h0_0100, 1'b0, 2'd0, 1'b0, 1'b0, "R4 clear flags");
        reg_wr(2'd0, 32'd1);
        access(18'h0_0200, 1'b1, 2'd1, 1'b0, 1'b1, "R2 enc01 ram boot");

        // random sweep below chip lock
        reg_wr(2'd0, 32'd0);
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) reg_wr(2'd0, 32'($urandom_range(0, 2)));
            else if (op == 1) reg_wr(2'd1, $urandom);
            else if (op == 2) reg_wr(2'd2, 32'($urandom_range(0, 1)));
            else access(18'($urandom), 1'($urandom), 2'($urandom), ($urandom_range(0, 3) == 0),
                        ($urandom_range(0, 3) == 0), lvl_tag(m_lvl));
        end

        // R5/R6: chip lock cannot be lowered
        reg_wr(2'd1, 32'h0000_0003);
        reg_wr(2'd0, 32'd3);
        reg_wr(2'd0, 32'd0);
        reg_rd(2'd0, rd); chk(rd == 32'd3, "R6 level frozen", rd, 32'd3);
        reg_wr(2'd1, 32'd0);
        reg_rd(2'd1, rd); chk(rd == 32'd3, "R6 mask frozen", rd, 32'd3);
        access(18'h0_1000, 1'b1, 2'd0, 1'b0, 1'b0, "R6 protection kept");
        access(18'h0_9000, 1'b0, 2'd3, 1'b0, 1'b0, "R5 debug master");
        access(18'h0_9000, 1'b0, 2'd1, 1'b1, 1'b1, "R5 cpu with flags");
        for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 4) == 0) reg_wr(2'($urandom_range(0, 1)), $urandom);
            else access(18'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), "R5");
        end

        // R1: reset with chip lock stored, then with open stored
        do_reset(2'b11, 32'hFFFF_0000);
        @(negedge clk);
        chk(dbg_port_en == 1'b0, "R1 lock from boot", 32'(dbg_port_en), 32'd0);
        reg_rd(2'd1, rd); chk(rd == 32'hFFFF_0000, "R1 mask reload", rd, 32'hFFFF_0000);
        do_reset(2'b00, 32'd0);
        @(negedge clk);
        chk(dbg_port_en == 1'b1 && ram_boot_en == 1'b1, "R1 reset reloads", 32'(dbg_port_en), 32'd1);
        access(18'h0_1000, 1'b1, 2'd3, 1'b1, 1'b0, "R3 after reload");

        summary();
        $finish;
    end

endmodule